// File: doc/BRIEF.md
# Dual Down-Counting Bus Timer

A register-mapped peripheral with two independent decrementing counters, reached over a simple 32-bit APB-style bus. Software picks a reload value, a clock prescale, a counter width (16 or 32 bits) and a counting mode for each timer: free-running, periodic or one-shot. Each timer flags a pending event when its count reaches zero and drives its own interrupt line while interrupts are enabled.

Each timer owns a 32-byte window. One word loads the counter and the reload value together. Another changes only the reload value, so a new period starts at the next wrap. Software can also overwrite the live count directly. A row of constant identification bytes sits at the top of the 4 KB window. The bus, the counters and the prescalers all run on one clock.

Top module: `dual_dec_timer`

## Requirements
- R1: Timer t uses byte offsets 0x20*t + {0x00 load, 0x04 count, 0x08 control, 0x0C event clear, 0x10 raw event, 0x14 masked event, 0x18 reload-only}. The clear offset and offset 0x1C read as zero, and so does every offset outside the timer windows and the identification window. A write happens on a cycle with psel_i, penable_i and pwrite_i all high. Reads return data combinationally from paddr_i, and address bits 1:0 are ignored.
- R2: After reset each control register reads 0x20 and each count reads 0x0000FFFF (all ones, shown in 16-bit width). The load word, the raw event, the masked event and irq_o are all zero.
- R3: Control bits are: 7 run, 6 periodic, 5 interrupt enable, 3:2 prescale code, 1 wide (32-bit), 0 one-shot. Bit 4 and bits 31:8 are dropped on write and read as zero. A control write takes effect on the next cycle.
- R4: A write to the load word sets both the live count and the reload value. A write to the reload-only word changes the reload value and leaves the count alone. Both offsets read back the reload value.
- R5: A write to the count word sets the live count and leaves the reload value unchanged.
- R6: While the run bit is set the count drops by one on each prescaled tick. With the run bit clear the count holds and the other control fields keep their values.
- R7: Prescale code 00 gives a tick every cycle, 01 every 16th cycle and 10 or 11 every 256th cycle. The prescale phase restarts when the timer is stopped and on a write to the load or count word, so the first tick after such a write comes 1, 16 or 256 cycles later.
- R8: In periodic mode (bit 6 set, bit 0 clear), a tick at count zero reloads the reload value masked to the width. A reload value N gives one event every N+1 ticks.
- R9: In free-running mode (bits 6 and 0 clear), a tick at count zero wraps the count to all ones of the selected width.
- R10: In one-shot mode (bit 0 set, whatever bit 6 holds) the count stays at zero until software writes the load or count word.
- R11: With bit 1 clear only the low 16 bits count, compare and wrap, and bits 31:16 of the count read as zero.
- R12: The raw event bit (bit 0) is set by a tick that moves the count from 1 to 0. A tick in the same cycle as a load or count write sets nothing. Any write to the clear offset clears the bit. If a set and a clear fall in the same cycle, the set wins.
- R13: The masked event bit (bit 0) and irq_o[t] both equal the raw event bit ANDed with control bit 5.
- R14: Byte offsets 0xFE0 + 4*k (k = 0..7) read ID_BYTES[8k+7:8k] in bits 7:0, with zeros above. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | High for a write access |
| paddr_i | input | ADDR_W (12) | Byte address in the 4 KB window |
| pwdata_i | input | DATA_W (32) | Write data |
| prdata_o | output | DATA_W (32) | Read data for paddr_i |
| irq_o | output | N_TIMERS (2) | Per-timer interrupt, raw event AND interrupt enable |

## Verification
The bound checker watches properties that must hold on every cycle. A stopped timer's count stays fixed unless there is a bus write. A 16-bit count has a zero upper half. The raw event falls only after a bus write and rises only with the count at zero. A one-shot timer at zero stays there. An interrupt requires both the raw event and its enable. Some behaviours only the bench scenarios can show, by comparing against the reference model on every clock. These are the exact tick spacing for each prescale code, the reload and wrap values, the period set by a reload-only write, set-over-clear priority, and the fixed identification bytes.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned CTL_RUN = 7;
  localparam int unsigned CTL_PER = 6;
  localparam int unsigned CTL_IE  = 5;
  localparam int unsigned CTL_PSH = 3;
  localparam int unsigned CTL_PSL = 2;
  localparam int unsigned CTL_W32 = 1;
  localparam int unsigned CTL_ONE = 0;
  localparam logic [7:0]  CTL_WMASK = 8'hEF;
  localparam logic [7:0]  CTL_RESET = 8'h20;

  typedef enum logic [2:0] {
    REG_LOAD = 3'd0,
    REG_VAL  = 3'd1,
    REG_CTL  = 3'd2,
    REG_CLR  = 3'd3,
    REG_RAW  = 3'd4,
    REG_MIS  = 3'd5,
    REG_BG   = 3'd6,
    REG_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
  parameter int unsigned PS_W   = 8,
  parameter int unsigned FINE_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] code_i,
  output logic       tick_o
);
  localparam logic [PS_W-1:0] FINE_MASK   = PS_W'((1 << FINE_W) - 1);
  localparam logic [PS_W-1:0] COARSE_MASK = '1;

  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  always_comb begin
    unique case (code_i)
      2'b00:   mask = '0;
      2'b01:   mask = FINE_MASK;
      default: mask = COARSE_MASK;
    endcase
  end

  assign tick_o = run_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
  import dtmr_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned PS_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  reg_sel_e     reg_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] load_o,
  output logic [7:0]   ctl_o,
  output logic         raw_o,
  output logic         irq_o
);
  localparam int unsigned HALF_W = W / 2;
  localparam logic [W-1:0] NARROW = {{(W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [W-1:0] cnt_q, load_q, cnt_d, mask, cm;
  logic [7:0]   ctl_q;
  logic         raw_q, tick;
  logic         ld_w, val_w, ctl_w, clr_w, bg_w, hit_zero;

  assign ld_w  = wr_i && (reg_i == REG_LOAD);
  assign val_w = wr_i && (reg_i == REG_VAL);
  assign ctl_w = wr_i && (reg_i == REG_CTL);
  assign clr_w = wr_i && (reg_i == REG_CLR);
  assign bg_w  = wr_i && (reg_i == REG_BG);

  assign mask = ctl_q[CTL_W32] ? '1 : NARROW;
  assign cm   = cnt_q & mask;

  dtmr_prescale #(.PS_W(PS_W)) u_ps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctl_q[CTL_RUN]),
    .restart_i(ld_w || val_w),
    .code_i   (ctl_q[CTL_PSH:CTL_PSL]),
    .tick_o   (tick)
  );

  // count reaches zero on this tick, unless software overrides the count
  assign hit_zero = tick && !ld_w && !val_w && (cm == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (ld_w || val_w)          cnt_d = wdata_i;
    else if (tick) begin
      if (cm != '0)             cnt_d = cm - 1'b1;
      else if (ctl_q[CTL_ONE])  cnt_d = cnt_q;
      else if (ctl_q[CTL_PER])  cnt_d = load_q & mask;
      else                      cnt_d = mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      load_q <= '0;
      ctl_q  <= CTL_RESET;
      raw_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ld_w || bg_w) load_q <= wdata_i;
      if (ctl_w)        ctl_q  <= wdata_i[7:0] & CTL_WMASK;
      raw_q <= hit_zero || (raw_q && !clr_w);
    end
  end

  assign val_o  = cm;
  assign load_o = load_q;
  assign ctl_o  = ctl_q;
  assign raw_o  = raw_q;
  assign irq_o  = raw_q && ctl_q[CTL_IE];
endmodule

// File: rtl/dual_dec_timer.sv
module dual_dec_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned N_TIMERS = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PS_W     = 8,
  parameter logic [63:0] ID_BYTES = 64'hA6197EC30002315A
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  output logic [DATA_W-1:0]   prdata_o,
  output logic [N_TIMERS-1:0] irq_o
);
  localparam int unsigned WIN_LSB = 5;
  localparam int unsigned IDX_W   = ADDR_W - WIN_LSB;
  localparam logic [IDX_W-1:0] ID_WIN = '1;

  logic                             bus_wr;
  logic [IDX_W-1:0]                 win;
  reg_sel_e                         rsel;
  logic [N_TIMERS-1:0][DATA_W-1:0]  val_w, load_w;
  logic [N_TIMERS-1:0][7:0]         ctl_w;
  logic [N_TIMERS-1:0]              raw_w;
  logic                             unused_lsb;

  assign bus_wr     = psel_i && penable_i && pwrite_i;
  assign win        = paddr_i[ADDR_W-1:WIN_LSB];
  assign rsel       = reg_sel_e'(paddr_i[4:2]);
  assign unused_lsb = ^paddr_i[1:0];

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    dtmr_core #(.W(DATA_W), .PS_W(PS_W)) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (bus_wr && (win == IDX_W'(g))),
      .reg_i  (rsel),
      .wdata_i(pwdata_i),
      .val_o  (val_w[g]),
      .load_o (load_w[g]),
      .ctl_o  (ctl_w[g]),
      .raw_o  (raw_w[g]),
      .irq_o  (irq_o[g])
    );
  end

  always_comb begin
    prdata_o = '0;
    if (win == ID_WIN) begin
      prdata_o = DATA_W'(ID_BYTES[{paddr_i[4:2], 3'b000} +: 8]);
    end else begin
      for (int i = 0; i < N_TIMERS; i++) begin
        if (win == IDX_W'(i)) begin
          unique case (rsel)
            REG_LOAD, REG_BG: prdata_o = load_w[i];
            REG_VAL:          prdata_o = val_w[i];
            REG_CTL:          prdata_o = DATA_W'(ctl_w[i]);
            REG_RAW:          prdata_o = DATA_W'(raw_w[i]);
            REG_MIS:          prdata_o = DATA_W'(raw_w[i] && ctl_w[i][CTL_IE]);
            default:          prdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int unsigned N_TIMERS = 2,
  parameter int unsigned DATA_W   = 32
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_i,
  input logic [N_TIMERS-1:0][DATA_W-1:0] val_i,
  input logic [N_TIMERS-1:0][7:0]        ctl_i,
  input logic [N_TIMERS-1:0]             raw_i,
  input logic [N_TIMERS-1:0]             irq_i
);
  for (genvar g = 0; g < N_TIMERS; g++) begin : g_chk
    // R6
    stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_i[g][7] && !wr_i) |=> $stable(val_i[g]));
    // R11
    narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl_i[g][1] |-> (val_i[g][DATA_W-1:DATA_W/2] == '0));
    // R12
    raw_clear_by_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(raw_i[g]) |-> $past(wr_i));
    // R12
    raw_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_i[g]) |-> (val_i[g] == '0));
    // R10
    one_shot_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i[g][7] && ctl_i[g][0] && (val_i[g] == '0) && !wr_i) |=> (val_i[g] == '0));
    // R13
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[g] |-> (raw_i[g] && ctl_i[g][5]));
  end
endmodule

bind dual_dec_timer dtmr_chk #(.N_TIMERS(N_TIMERS), .DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .wr_i  (bus_wr),
  .val_i (val_w),
  .ctl_i (ctl_w),
  .raw_i (raw_w),
  .irq_i (irq_o)
);

// File: tb/dual_dec_timer_tb.sv
module dual_dec_timer_tb_top;
  localparam logic [63:0] IDB = 64'hA6197EC30002315A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [11:0] paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic [1:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  dual_dec_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
    .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i),
    .prdata_o(prdata_o), .irq_o(irq_o)
  );

  // reference model state
  logic [31:0] m_load [2];
  logic [31:0] m_cnt  [2];
  logic [7:0]  m_ctl  [2];
  logic        m_raw  [2];
  int          m_pre  [2];

  function automatic logic [31:0] m_mask(int t);
    return m_ctl[t][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int w = int'(a[11:5]);
    int r = int'(a[4:2]);
    if (w == 127) return {24'h0, IDB[r*8 +: 8]};
    if (w > 1) return 32'h0;
    case (r)
      0, 6: return m_load[w];
      1:    return m_cnt[w] & m_mask(w);
      2:    return {24'h0, m_ctl[w]};
      4:    return {31'h0, m_raw[w]};
      5:    return {31'h0, m_raw[w] & m_ctl[w][5]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < 2; t++) begin
        m_load[t] = 32'h0; m_cnt[t] = 32'hFFFF_FFFF; m_ctl[t] = 8'h20;
        m_raw[t] = 1'b0; m_pre[t] = 0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        bit wr, ld, vw, cw, clr, bg, run, tick, setz;
        int dv;
        logic [31:0] cm;
        wr  = psel_i && penable_i && pwrite_i && (int'(paddr_i[11:5]) == t);
        ld  = wr && paddr_i[4:2] == 3'd0;
        vw  = wr && paddr_i[4:2] == 3'd1;
        cw  = wr && paddr_i[4:2] == 3'd2;
        clr = wr && paddr_i[4:2] == 3'd3;
        bg  = wr && paddr_i[4:2] == 3'd6;
        run = m_ctl[t][7];
        dv  = (m_ctl[t][3:2] == 2'b00) ? 1 : (m_ctl[t][3:2] == 2'b01) ? 16 : 256;
        tick = run && ((m_pre[t] % dv) == dv - 1);
        cm  = m_cnt[t] & m_mask(t);
        setz = tick && !ld && !vw && cm == 32'd1;
        if (ld || vw) m_cnt[t] = pwdata_i;
        else if (tick) begin
          if (cm != 0) m_cnt[t] = cm - 1;
          else if (m_ctl[t][0]) m_cnt[t] = m_cnt[t];
          else if (m_ctl[t][6]) m_cnt[t] = m_load[t] & m_mask(t);
          else m_cnt[t] = m_mask(t);
        end
        m_pre[t] = (!run || ld || vw) ? 0 : (m_pre[t] + 1) % 256;
        if (setz) m_raw[t] = 1'b1;
        else if (clr) m_raw[t] = 1'b0;
        if (ld || bg) m_load[t] = pwdata_i;
        if (cw) m_ctl[t] = pwdata_i[7:0] & 8'hEF;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // R13: interrupt lines against the model on every clock
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int t = 0; t < 2; t++)
        check("R13 irq_o", {31'h0, irq_o[t]}, {31'h0, m_raw[t] & m_ctl[t][5]});
    end
  end

  task automatic rd(logic [11:0] a, string req);
    paddr_i = a; #1;
    check(req, prdata_o, m_read(a));
  endtask

  task automatic rd_lit(logic [11:0] a, logic [31:0] exp, string req);
    paddr_i = a; #1;
    check(req, prdata_o, exp);
  endtask

  task automatic scan(int n);
    repeat (n) begin
      @(negedge clk_i);
      for (int t = 0; t < 2; t++) begin
        rd(12'(t * 32 + 4),  "R6 count");
        rd(12'(t * 32 + 16), "R12 raw");
        rd(12'(t * 32 + 20), "R13 masked");
      end
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 reset state
    rd_lit(12'h008, 32'h20,       "R2 ctl0");
    rd_lit(12'h028, 32'h20,       "R2 ctl1");
    rd_lit(12'h004, 32'h0000FFFF, "R2 count0");
    rd_lit(12'h024, 32'h0000FFFF, "R2 count1");
    rd_lit(12'h000, 32'h0,        "R2 load0");
    rd_lit(12'h010, 32'h0,        "R2 raw0");
    check("R2 irq", {30'h0, irq_o}, 32'h0);
    // R14 identification bytes, R1 unmapped
    for (int k = 0; k < 8; k++) rd_lit(12'(12'hFE0 + k * 4), {24'h0, IDB[k*8 +: 8]}, "R14 id");
    wr(12'hFE4, 32'hFFFF_FFFF);
    rd_lit(12'hFE4, {24'h0, IDB[15:8]}, "R14 id after write");
    rd_lit(12'h01C, 32'h0, "R1 gap");
    rd_lit(12'h00C, 32'h0, "R1 clear reads zero");
    rd_lit(12'h040, 32'h0, "R1 unmapped");
    rd_lit(12'h800, 32'h0, "R1 unmapped mid");
    rd_lit(12'hFDC, 32'h0, "R1 below id");
    rd_lit(12'h00A, 32'h20, "R1 low bits ignored");
    // R3 control readback, bit 4 dropped
    wr(12'h008, 32'hFFFF_FF1F);
    rd_lit(12'h008, 32'h0F, "R3 ctl readback");
    wr(12'h008, 32'h0);
    // R8 periodic div1 32-bit with irq, R12 clear
    wr(12'h000, 32'd5);
    wr(12'h008, 32'hE2);
    scan(20);
    wr(12'h00C, 32'h0);
    rd_lit(12'h010, 32'h0, "R12 cleared");
    scan(10);
    // R4 reload-only write keeps count, new period next
    wr(12'h018, 32'd2);
    rd(12'h004, "R4 count kept");
    rd_lit(12'h000, 32'd2, "R4 reload readback");
    scan(20);
    // R12 set-versus-clear sweep
    for (int k = 0; k < 6; k++) begin
      wr(12'h000, 32'd3);
      scan(k);
      wr(12'h00C, 32'h1);
      scan(2);
    end
    // R6 stop keeps settings; R5 count write
    wr(12'h008, 32'h62);
    scan(5);
    rd_lit(12'h008, 32'h62, "R6 settings kept");
    wr(12'h004, 32'h1234_5678);
    rd_lit(12'h004, 32'h1234_5678, "R5 count write");
    rd_lit(12'h000, 32'd3, "R5 reload untouched");
    scan(5);
    // R9 free-running wrap, interrupts off
    wr(12'h00C, 32'h0);
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h82);
    scan(6);
    rd(12'h004, "R9 wrapped");
    // R10 one-shot
    wr(12'h000, 32'd4);
    wr(12'h008, 32'hA3);
    scan(12);
    rd_lit(12'h004, 32'h0, "R10 parked");
    wr(12'h000, 32'd2);
    scan(6);
    // R11 16-bit free-running
    wr(12'h008, 32'h80);
    wr(12'h000, 32'h1234_0002);
    rd_lit(12'h004, 32'h0000_0002, "R11 low half");
    scan(6);
    // R7 prescale codes, timer 1 (R1 offset stride)
    wr(12'h020, 32'd3);
    wr(12'h028, 32'hE6);
    scan(80);
    wr(12'h02C, 32'h0);
    wr(12'h028, 32'hEA);
    wr(12'h020, 32'd2);
    scan(800);
    wr(12'h028, 32'hEE);
    wr(12'h024, 32'd1);
    scan(600);
    // both timers together
    wr(12'h000, 32'd7);
    wr(12'h008, 32'hE2);
    wr(12'h028, 32'hE2);
    wr(12'h020, 32'd4);
    scan(40);
    summary();
    $finish;
  end
endmodule